// File: doc/BRIEF.md
# Mode-Selected Up/Down Cascadable Counter

This block is a synchronous binary counter, eight bits wide by default, whose behaviour on each clock is chosen by a two-bit mode word. One mode empties the register at once without waiting for a clock. A second mode copies a parallel data word into the register on the rising edge. The other two modes count up or count down. Counting also needs two active-low enables. One is a stage-local count enable. The other is a chain enable that is passed through to the carry output without a register.

The active-low carry output goes low only when both enables are low and the count sits at the last value for the selected direction: all ones when counting up, all zeros when counting down. A wider counter is built by feeding one stage's carry into the chain enable of the next stage, with every stage on the same clock. No extra gating is needed.

Internally, the mode word and the enables are decoded into one action per cycle. The actions are ACT_CLEAR, ACT_HOLD, ACT_LOAD, ACT_INC and ACT_DEC. The count register works as the state register, and its transitions are these:
- clear: any state goes to zero, asynchronously.
- load: any state goes to the data word.
- increment: N goes to N+1, and all ones wraps to zero.
- decrement: N goes to N-1, and zero wraps to all ones.
- hold: N stays at N.

Top module: `updn_mode_counter`

## Requirements
- R1: The mode word selects the function: 2'b00 clear, 2'b01 count down, 2'b10 parallel load, 2'b11 count up.
- R2: While the mode word is 2'b00, the count is zero at once with no clock edge, and it stays zero over clock edges.
- R3: In load mode, the count takes the value of the data input at the next rising edge, whatever the enables are.
- R4: In count-up mode with both enables low, each rising edge adds one, and all ones wraps to zero.
- R5: In count-down mode with both enables low, each rising edge subtracts one, and zero wraps to all ones.
- R6: In either count mode, if either enable is high the count keeps its value across the edge.
- R7: The carry output is low when the mode is count-up, both enables are low and the count is all ones.
- R8: The carry output is low when the mode is count-down, both enables are low and the count is zero.
- R9: The carry output is high in every other case. This includes load mode, clear mode, either enable high, and any count that is not terminal. It follows the chain enable with no clock edge in between.
- R10: Two stages, with the low stage's carry driving the high stage's chain enable, count as one 16-bit counter up and down, including the wrap at 16'hFFFF/16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mode | input | 2 | Function select (00 clear, 01 down, 10 load, 11 up) |
| data_in | input | WIDTH | Parallel load value |
| cnt_en_n | input | 1 | Stage-local count enable, active low |
| chain_en_n | input | 1 | Chain enable, active low, gates the carry output |
| count_q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
The assertions check the following on every cycle:
- the register step for each decoded action (hold, load, increment and decrement);
- that the count is zero while the clear mode is applied;
- that a low carry only ever appears with both enables low and a terminal count for the current direction.

Other behaviours depend on a sequence of stimulus and are shown only by the bench's scenarios:
- the clear taking effect between clock edges;
- the carry following the chain enable without a clock;
- the wrap in each direction;
- the two-stage chain behaving as one 16-bit counter against a behavioural model.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_DOWN  = 2'b01,
        MODE_LOAD  = 2'b10,
        MODE_UP    = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ACT_CLEAR,
        ACT_HOLD,
        ACT_LOAD,
        ACT_INC,
        ACT_DEC
    } act_e;

endpackage

// File: rtl/updn_mode_decode.sv
module updn_mode_decode
    import updn_ctr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       cnt_en_n,
    input  logic       chain_en_n,
    output mode_e      mode_s,
    output act_e       act,
    output logic       clr
);

    logic run;

    assign mode_s = mode_e'(mode);
    assign run    = ~cnt_en_n & ~chain_en_n;

    always_comb begin
        act = ACT_HOLD;
        unique case (mode_s)
            MODE_CLEAR: act = ACT_CLEAR;
            MODE_LOAD:  act = ACT_LOAD;
            MODE_UP:    act = run ? ACT_INC : ACT_HOLD;
            MODE_DOWN:  act = run ? ACT_DEC : ACT_HOLD;
        endcase
    end

    assign clr = (act == ACT_CLEAR);

endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  act_e             act,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count_q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] count_d;

    always_comb begin
        count_d = count_q;
        unique case (act)
            ACT_CLEAR: count_d = '0;
            ACT_HOLD:  count_d = count_q;
            ACT_LOAD:  count_d = data_in;
            ACT_INC:   count_d = count_q + ONE;
            ACT_DEC:   count_d = count_q - ONE;
            default:   count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) count_q <= '0;
        else     count_q <= count_d;
    end

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_LOAD) |=> (count_q == $past(data_in))); // R3
    AST_INC_STEP: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_INC) |=> (count_q == WIDTH'($past(count_q) + ONE))); // R4
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_DEC) |=> (count_q == WIDTH'($past(count_q) - ONE))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_HOLD) |=> $stable(count_q)); // R6

endmodule

// File: rtl/updn_carry_gen.sv
module updn_carry_gen
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  mode_e            mode_s,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic [WIDTH-1:0] count_q,
    output logic             carry_n
);

    logic at_top, at_bottom, terminal;

    assign at_top    = &count_q;
    assign at_bottom = ~|count_q;

    always_comb begin
        terminal = 1'b0;
        unique case (mode_s)
            MODE_UP:    terminal = at_top;
            MODE_DOWN:  terminal = at_bottom;
            MODE_LOAD:  terminal = 1'b0;
            MODE_CLEAR: terminal = 1'b0;
        endcase
    end

    assign carry_n = ~(terminal & ~cnt_en_n & ~chain_en_n);

    AST_CARRY_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (clr)
        (cnt_en_n || chain_en_n || mode_s == MODE_LOAD) |-> carry_n); // R9
    AST_CARRY_UP_TERMINAL: assert property (@(posedge clk) disable iff (clr)
        (!carry_n && mode_s == MODE_UP) |-> (count_q == {WIDTH{1'b1}})); // R7
    AST_CARRY_DOWN_TERMINAL: assert property (@(posedge clk) disable iff (clr)
        (!carry_n && mode_s == MODE_DOWN) |-> (count_q == '0)); // R8

endmodule

// File: rtl/updn_mode_counter.sv
module updn_mode_counter
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] data_in,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_n
);

    mode_e mode_s;
    act_e  act;
    logic  clr;

    updn_mode_decode u_dec (
        .mode       (mode),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .mode_s     (mode_s),
        .act        (act),
        .clr        (clr)
    );

    updn_count_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .clr     (clr),
        .act     (act),
        .data_in (data_in),
        .count_q (count_q)
    );

    updn_carry_gen #(.WIDTH(WIDTH)) u_carry (
        .clk        (clk),
        .clr        (clr),
        .mode_s     (mode_s),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .count_q    (count_q),
        .carry_n    (carry_n)
    );

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        (mode == 2'b00) |-> (count_q == '0 && carry_n)); // R2

endmodule

// File: tb/tb_updn_mode_counter.sv
module tb_updn_mode_counter;

    logic       clk = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] din = 8'h00;
    logic       enp = 1'b1, ent = 1'b1;
    logic [7:0] q;
    logic       co;

    logic [1:0] cmode = 2'b00;
    logic [15:0] cdin = 16'h0;
    logic       cen = 1'b1;
    logic [7:0] qlo, qhi;
    logic       colo, cohi;

    int checks = 0, fails = 0;
    int mdl = 0;
    int c16 = 0;

    always #10 clk = ~clk;

    updn_mode_counter #(.WIDTH(8)) dut (
        .clk(clk), .mode(mode), .data_in(din), .cnt_en_n(enp),
        .chain_en_n(ent), .count_q(q), .carry_n(co));

    updn_mode_counter #(.WIDTH(8)) stg_lo (
        .clk(clk), .mode(cmode), .data_in(cdin[7:0]), .cnt_en_n(cen),
        .chain_en_n(cen), .count_q(qlo), .carry_n(colo));

    updn_mode_counter #(.WIDTH(8)) stg_hi (
        .clk(clk), .mode(cmode), .data_in(cdin[15:8]), .cnt_en_n(cen),
        .chain_en_n(colo), .count_q(qhi), .carry_n(cohi));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_carry(int m, logic [1:0] md, logic p, logic t);
        if (p || t) return 1'b1;
        if (md == 2'b11 && m == 255) return 1'b0;
        if (md == 2'b01 && m == 0) return 1'b0;
        return 1'b1;
    endfunction

    // One cycle on the single stage: drive at negedge, check carry, clock, check count.
    task automatic cyc(input logic [1:0] md, input logic [7:0] d, input logic p,
                       input logic t, input string req);
        mode = md; din = d; enp = p; ent = t;
        #1;
        if (md == 2'b00) mdl = 0;
        chk(co == exp_carry(mdl, md, p, t), {req, " carry"}, int'(co),
            int'(exp_carry(mdl, md, p, t)));
        @(posedge clk);
        case (md)
            2'b00: mdl = 0;
            2'b10: mdl = d;
            2'b11: if (!p && !t) mdl = (mdl + 1) % 256;
            2'b01: if (!p && !t) mdl = (mdl + 255) % 256;
            default: ;
        endcase
        @(negedge clk);
        chk(q == mdl[7:0], {req, " count"}, int'(q), mdl);
    endtask

    // One cycle on the two-stage chain, compared with a 16-bit model.
    task automatic ccyc(input logic [1:0] md, input logic [15:0] d, input logic e);
        cmode = md; cdin = d; cen = e;
        @(posedge clk);
        case (md)
            2'b00: c16 = 0;
            2'b10: c16 = d;
            2'b11: if (!e) c16 = (c16 + 1) % 65536;
            2'b01: if (!e) c16 = (c16 + 65535) % 65536;
            default: ;
        endcase
        @(negedge clk);
        chk({qhi, qlo} == c16[15:0], "R10 chain", int'({qhi, qlo}), c16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R2: clear state
        chk(q == 8'h00, "R2 reset", int'(q), 0);
        chk(co == 1'b1, "R9 carry in clear", int'(co), 1);
        // R3: load, enables ignored
        cyc(2'b10, 8'hFD, 1'b0, 1'b0, "R3");
        cyc(2'b10, 8'h3C, 1'b1, 1'b1, "R3");
        // R1 R4 R7: count up through wrap
        cyc(2'b10, 8'hFD, 1'b1, 1'b1, "R1");
        for (int i = 0; i < 5; i++) cyc(2'b11, 8'h00, 1'b0, 1'b0, "R4 R7");
        // R6: hold via either enable
        cyc(2'b11, 8'h00, 1'b1, 1'b0, "R6");
        cyc(2'b11, 8'h00, 1'b0, 1'b1, "R6");
        // R9: ent feed-forward at terminal value
        cyc(2'b10, 8'hFF, 1'b0, 1'b0, "R9");
        cyc(2'b11, 8'h00, 1'b0, 1'b1, "R9");
        cyc(2'b11, 8'h00, 1'b1, 1'b0, "R9");
        cyc(2'b11, 8'h00, 1'b0, 1'b0, "R7");
        // R5 R8: count down through wrap
        cyc(2'b10, 8'h02, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) cyc(2'b01, 8'h00, 1'b0, 1'b0, "R5 R8");
        cyc(2'b01, 8'h00, 1'b1, 1'b1, "R6");
        cyc(2'b10, 8'h00, 1'b0, 1'b0, "R9");
        // R2: asynchronous clear between edges
        cyc(2'b10, 8'h5A, 1'b1, 1'b1, "R3");
        mode = 2'b00;
        #3;
        chk(q == 8'h00, "R2 async", int'(q), 0);
        mdl = 0;
        cyc(2'b00, 8'h77, 1'b0, 1'b0, "R2");

        // R10: 16-bit chain
        ccyc(2'b00, 16'h0, 1'b1);
        ccyc(2'b10, 16'hFFF0, 1'b1);
        for (int i = 0; i < 40; i++) ccyc(2'b11, 16'h0, (i % 7 == 3));
        for (int i = 0; i < 70; i++) ccyc(2'b01, 16'h0, (i % 9 == 4));
        ccyc(2'b10, 16'h0100, 1'b1);
        for (int i = 0; i < 4; i++) ccyc(2'b01, 16'h0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule